// File: doc/BRIEF.md
# Serial EEPROM Write Sequencer

This block turns one parallel write request from a host into a complete word write on a three-wire serial EEPROM bus. The bus has a select line, a serial clock and a data line toward the memory, plus a status line coming back from it. A write frame goes out most significant bit first. It holds a leading one, the two-bit write code `01`, the word address and a 16-bit data word. The frame ends by dropping select before any further clock rise, and that drop starts the memory's internal programming.

The block then keeps select low for a fixed deselect interval and raises it again. It watches the status line through a two-flop synchronizer. A low level on that line means the memory is still programming, and a high level means the write has finished. When ready is seen, the block releases select, pulses `done` and accepts the next request. If ready never arrives within a set number of cycles, the block pulses `err` instead.

The serial clock runs at a divided rate. The address width is a parameter, so arrays of different sizes can be served. The controller moves through four named states. `ST_IDLE` goes to `ST_SHIFT` on an accepted request. `ST_SHIFT` goes to `ST_DESEL` after the last falling serial-clock edge. `ST_DESEL` goes to `ST_POLL` when the deselect count expires. `ST_POLL` goes back to `ST_IDLE` either on synchronized ready (the done exit) or on expiry of the poll count (the timeout exit).

Top module: `eew_master`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are all low.
- R2: With `ee_cs` high, exactly 3+ADDR_W+16 rising `ee_sk` edges occur per request. The values of `ee_di` at those edges are, in order: 1, 0, 1, then the address from its top bit down, then the data from bit 15 down to bit 0.
- R3: `ee_di` changes only while `ee_sk` is low. While `ee_cs` is high during shifting, every high or low half of `ee_sk` lasts exactly CLK_DIV clock cycles.
- R4: `ee_cs` falls on the same cycle as the final falling `ee_sk` edge, so no rising edge follows the last data bit. `ee_sk` is never high while `ee_cs` is low.
- R5: Between the end of the frame and the start of polling, `ee_cs` stays low for exactly DESEL_CYC clock cycles.
- R6: During polling `ee_cs` is high. `done` pulses for exactly one cycle, three cycles after `ee_do` is first high while select is high. On that same cycle `ee_cs` and `busy` drop.
- R7: The level on `ee_do` while `ee_cs` is low has no effect: the synchronizer is cleared outside polling, so a high level there does not shorten the poll.
- R8: If ready is not seen, `ee_cs` stays high for exactly TIMEOUT_CYC cycles of polling. `err` then pulses for one cycle together with the fall of `ee_cs`, and `done` stays low.
- R9: `busy` is high from the cycle after an accepted `req` until the cycle of `done` or `err`. A `req` seen while `busy` is high is ignored and does not alter the frame being sent.
- R10: A request issued on the cycle right after `done` or `err` is accepted and produces a correct frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Write request strobe, taken only when idle |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Data word |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle pulse: write confirmed ready |
| err | output | 1 | One-cycle pulse: ready poll timed out |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Status from the memory (low busy, high ready) |

## Verification
The hardest case to reach is a status line that the memory model pulls high while select is low. The question there is whether `done` still appears exactly three cycles after polling starts. The second hard case is the opposite one: ready arrives well inside the poll, so the synchronizer delay is measured from the ready edge instead of from the rise of select. The bench reaches both cases by giving each write its own programming delay. Short delays end during the deselect interval and long ones end during polling. The bench sweeps every address of a 4-bit configuration this way, then adds a device that never becomes ready and requests injected while the block is busy.

// File: rtl/eew_pkg.sv
package eew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DESEL,
        ST_POLL
    } eew_state_e;

    // leading one followed by the write code 01
    localparam logic [2:0] WR_HDR = 3'b101;
    localparam int HDR_W = 3;
endpackage

// File: rtl/eew_div.sv
module eew_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV > 1 ? DIV : 2);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == CNT_W'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == CNT_W'(DIV - 1));
endmodule

// File: rtl/eew_shreg.sv
module eew_shreg #(
    parameter int FRAME_W = 29
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               run,
    input  logic               tick,
    output logic               sk,
    output logic               di,
    output logic               fin
);
    localparam int LEFT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sr;
    logic [LEFT_W-1:0]  left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            left <= '0;
            sk   <= 1'b0;
        end else if (load) begin
            sr   <= frame_in;
            left <= LEFT_W'(FRAME_W);
            sk   <= 1'b0;
        end else if (run && tick) begin
            if (!sk) begin
                sk <= 1'b1;
            end else begin
                sk   <= 1'b0;
                sr   <= {sr[FRAME_W-2:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end

    assign di  = sr[FRAME_W-1];
    assign fin = run && tick && sk && (left == LEFT_W'(1));

    // bit counter never leaves its legal range
    assert_left_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        left <= LEFT_W'(FRAME_W));
endmodule

// File: rtl/eew_sync.sv
module eew_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else if (clr) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/eew_master.sv
module eew_master
    import eew_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int CLK_DIV     = 4,
    parameter int DESEL_CYC   = 25,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);
    localparam int FRAME_W  = HDR_W + ADDR_W + DATA_W;
    localparam int WAIT_MAX = (DESEL_CYC > TIMEOUT_CYC) ? DESEL_CYC : TIMEOUT_CYC;
    localparam int WCNT_W   = $clog2(WAIT_MAX + 1);

    eew_state_e        state, nxt;
    logic [WCNT_W-1:0] wcnt;
    logic              tick, fin, rdy_s, load;
    logic              desel_end, poll_end;

    assign load      = (state == ST_IDLE) && req;
    assign desel_end = (wcnt == WCNT_W'(DESEL_CYC - 1));
    assign poll_end  = (wcnt == WCNT_W'(TIMEOUT_CYC - 1));

    eew_div #(.DIV(CLK_DIV)) div_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_SHIFT),
        .tick (tick)
    );

    eew_shreg #(.FRAME_W(FRAME_W)) shreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .frame_in({WR_HDR, addr, wdata}),
        .run     (state == ST_SHIFT),
        .tick    (tick),
        .sk      (ee_sk),
        .di      (ee_di),
        .fin     (fin)
    );

    eew_sync sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != ST_POLL),
        .d    (ee_do),
        .q    (rdy_s)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req)       nxt = ST_SHIFT;
            ST_SHIFT: if (fin)       nxt = ST_DESEL;
            ST_DESEL: if (desel_end) nxt = ST_POLL;
            ST_POLL:  if (rdy_s || poll_end) nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shared deselect / poll counter, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (state != nxt) begin
            wcnt <= '0;
        end else if (state == ST_DESEL || state == ST_POLL) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_cs <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            ee_cs <= (nxt == ST_SHIFT) || (nxt == ST_POLL);
            done  <= (state == ST_POLL) && rdy_s;
            err   <= (state == ST_POLL) && !rdy_s && poll_end;
        end
    end

    assign busy = (state != ST_IDLE);

    assert_di_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    assert_sk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !ee_cs));

    assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_cs_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $fell(ee_sk) && $past(state == ST_SHIFT) && (state == ST_DESEL)) |-> !ee_cs);
endmodule

// File: tb/eew_master_tb.sv
module eew_master_tb_top;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int DIV = 2;
    localparam int DSL = 25;
    localparam int TMO = 120;
    localparam int FW  = 3 + AW + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          busy, done, err, ee_cs, ee_sk, ee_di, ee_do;
    logic          dev_rdy = 1'b0;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    // memory status line: driven only while selected, pulled high otherwise
    assign ee_do = ee_cs ? dev_rdy : 1'b1;

    eew_master #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_DIV(DIV),
        .DESEL_CYC(DSL), .TIMEOUT_CYC(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .err(err),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one write: busy_len = cycles after select drop until the memory reports ready
    task automatic write_txn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input int busy_len, input bit never_rdy, input int inj_at);
        logic [FW-1:0] cap;
        logic [FW-1:0] exp_frame;
        int  phase, rises, run, bad_half, bad_di, fall_idx, p, k, end_idx;
        bit  prev_cs, prev_sk, prev_di, finished, got_done, got_err, early;
        cap = '0; phase = 0; rises = 0; run = 0; bad_half = 0; bad_di = 0;
        fall_idx = 0; p = -1; k = -1; end_idx = -1;
        prev_cs = 0; prev_sk = 0; prev_di = 0; finished = 0;
        got_done = 0; got_err = 0; early = 0;
        exp_frame = {3'b101, a, d};
        dev_rdy = 1'b0;

        @(negedge clk);
        req = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; addr = ~a; wdata = ~d;
        check(busy == 1'b1, "R9 busy after accepted req", busy, 1);

        for (int n = 0; n < 3000 && !finished; n++) begin
            if (n > 0) @(negedge clk);
            if (n == inj_at) begin
                req = 1'b1; addr = ~a; wdata = d ^ 16'hFFFF;
            end else begin
                req = 1'b0;
            end
            if ((done || err) && phase < 2) early = 1;
            // half-period and data stability tracking while selected
            if (prev_cs) begin
                if (ee_sk != prev_sk) begin
                    if (run != DIV) bad_half++;
                    run = 1;
                end else begin
                    run++;
                end
                if (prev_sk && ee_sk && (ee_di != prev_di)) bad_di++;
            end else if (ee_cs) begin
                run = 1;
            end
            if (ee_cs && ee_sk && !prev_sk) begin
                rises++;
                cap = {cap[FW-2:0], ee_di};
            end
            if (!ee_cs && ee_sk) bad_half++;
            if (phase == 0 && prev_cs && !ee_cs) begin
                phase = 1;
                fall_idx = n;
                check(ee_sk == 1'b0, "R4 sk low when select drops", ee_sk, 0);
            end else if (phase == 1 && ee_cs) begin
                phase = 2;
                p = n;
                check(n - fall_idx == DSL, "R5 deselect length", n - fall_idx, DSL);
            end else if (phase == 2 && (done || err)) begin
                end_idx = n;
                got_done = done;
                got_err = err;
                finished = 1;
                check(ee_cs == 1'b0 && busy == 1'b0, "R6/R8 select and busy drop at end",
                      {ee_cs, busy}, 0);
            end
            // memory model
            if (phase >= 1 && !never_rdy && (n - fall_idx) >= busy_len) begin
                if (k < 0) k = n;
                dev_rdy = 1'b1;
            end
            prev_cs = ee_cs; prev_sk = ee_sk; prev_di = ee_di;
        end
        req = 1'b0;

        check(!early, "R6 no done/err before polling", early, 0);
        check(rises == FW, "R2 rising edge count", rises, FW);
        check(cap == exp_frame, "R2/R9 frame content", cap, exp_frame);
        check(bad_half == 0, "R3/R4 serial clock half periods", bad_half, 0);
        check(bad_di == 0, "R3 data held while clock high", bad_di, 0);
        if (never_rdy) begin
            check(got_err && !got_done, "R8 timeout pulses err only", {got_err, got_done}, 2);
            check(end_idx - p == TMO, "R8 poll length on timeout", end_idx - p, TMO);
        end else begin
            check(got_done && !got_err, "R6 done only", {got_done, got_err}, 2);
            check(end_idx == ((k > p) ? k : p) + 3, "R6/R7 done latency",
                  end_idx, ((k > p) ? k : p) + 3);
        end
        @(negedge clk);
        check(!done && !err && !busy, "R6 one-cycle pulse then idle", {done, err, busy}, 0);
        dev_rdy = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check({ee_cs, ee_sk, ee_di, busy, done, err} == 6'b0, "R1 outputs in reset",
              {ee_cs, ee_sk, ee_di, busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({ee_cs, ee_sk, ee_di, busy, done, err} == 6'b0, "R1 outputs after reset",
              {ee_cs, ee_sk, ee_di, busy, done, err}, 0);

        // exhaustive address sweep, data computed per address, ready in deselect or in poll
        for (int a = 0; a < (1 << AW); a++) begin
            write_txn(AW'(a), 16'(a * 16'h1357) ^ 16'hC3A5, (a % 2 == 0) ? 5 : 40 + a, 1'b0, -1);
        end
        // data extremes (R2)
        write_txn('0, 16'h0000, 0, 1'b0, -1);
        write_txn('1, 16'hFFFF, 60, 1'b0, -1);
        // requests while busy: during shift and during poll (R9)
        write_txn(4'h9, 16'hA55A, 50, 1'b0, 7);
        write_txn(4'h6, 16'h0F0F, 70, 1'b0, FW * 2 * DIV + DSL + 10);
        // no ready: timeout (R8), then immediate recovery (R10)
        write_txn(4'h3, 16'h1234, 0, 1'b1, -1);
        write_txn(4'hC, 16'h8001, 20, 1'b0, -1);
        write_txn(4'h5, 16'h7FFE, 30, 1'b0, -1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule